// File: doc/BRIEF.md
# Predicate File with Masked Whole-File Transfer

This block holds a file of 64 one-bit predicates. Predicate 0 is fixed at one. Predicates 1 to 15 are static. Predicates 16 to 63 form a rotating region, and a six-bit rotation base renames them. Ordinary single-predicate reads and writes go through that renaming. Whole-file transfers do not.

A whole-file write takes a 64-bit value and a 17-bit group mask. Each static predicate has its own enable bit. All 48 rotating predicates share one enable bit. A whole-file read returns every physical entry as one 64-bit word, with bit N holding predicate N. Instruction decode and the general register file sit outside the block.

Single reads and whole-file reads are combinational from the stored state. Every write, including a rotation-base load, takes effect at the next rising clock edge.

Top module: `pred_xfer_top`

## Requirements
- R1: After synchronous active-low reset, predicates 1 to 63 read 0, predicate 0 reads 1, and the rotation base reads 0.
- R2: Predicate 0 always reads 1, and neither a single write nor a whole-file write can change it.
- R3: A single write to index 1 to 15 updates that same physical entry at the next edge. A single read of index 0 to 15 returns that entry with no renaming.
- R4: A single access to index I in 16..63 uses physical entry 16 + ((I - 16 + base) mod 48), where base is the rotation base. For example, I=60 with base=5 maps to entry 17, and I=63 with base=47 maps to entry 62.
- R5: The rotation base loads at the next edge when the load input is high and the offered value is 0 to 47. An offered value of 48 to 63 is ignored and the old base is kept.
- R6: The whole-file read output carries physical predicate N on bit N for all 64 N, with no renaming.
- R7: On a whole-file write, mask bit k (for k from 1 to 15) lets predicate k take value bit k. When mask bit k is clear, predicate k keeps its value.
- R8: Mask bit 16 enables predicates 16 to 63 together, each taking value bit N. Mask bit 0 is ignored.
- R9: A whole-file write ignores the rotation base and leaves it unchanged.
- R10: If a single write and an enabled whole-file write hit the same entry in the same cycle, the entry takes the whole-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | 6 | Single read index (logical) |
| rd_bit | output | 1 | Value of the predicate selected by rd_idx |
| wr_en | input | 1 | Single write enable |
| wr_idx | input | 6 | Single write index (logical) |
| wr_bit | input | 1 | Single write value |
| bulk_we | input | 1 | Whole-file write enable |
| bulk_val | input | 64 | Whole-file write value, bit N for predicate N |
| bulk_mask | input | 17 | Bits 1..15 enable static predicates; bit 16 enables predicates 16..63; bit 0 is unused |
| base_we | input | 1 | Rotation base load enable |
| base_val | input | 6 | Rotation base value to load |
| base_q | output | 6 | Current rotation base |
| bulk_out | output | 64 | Whole-file read value |

## Verification
Every write, whether single, whole-file or base load, becomes visible on rd_bit, bulk_out and base_q one edge after it is driven. Those outputs then follow the stored state with no further delay.

The driver applies each stimulus just after a rising edge and holds it through the next edge. It then pushes the expected outputs into the scoreboard queue. The monitor pops each item on the following falling edge, so every comparison lands exactly one edge after the stimulus and away from the edge itself.

// File: rtl/pred_pkg.sv
// Package: shared sizes and index type for the predicate transfer block.
// Assumes a power-of-two file of at most 64 entries.
package pred_pkg;
    localparam int PRED_N   = 64;
    localparam int STATIC_N = 16;
    localparam int IDX_W    = $clog2(PRED_N);
    typedef logic [IDX_W-1:0] pidx_t;
endpackage

// File: rtl/pred_rot_map.sv
// Module: pred_rot_map
// Turns a logical predicate index into a physical entry number.
// Indices below NSTAT pass through unchanged.
// Indices at or above NSTAT are shifted by the rotation base modulo the rotating-region size.
// Assumes base < NPRED - NSTAT.
module pred_rot_map #(
    parameter int NPRED = 64,
    parameter int NSTAT = 16,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] base,
    output logic [IW-1:0] phys
);
    localparam int NROT = NPRED - NSTAT;

    logic [IW:0] off;

    // Purpose: modular offset inside the rotating region, then re-add the region start.
    always_comb begin
        off = {1'b0, idx} - (IW+1)'(NSTAT) + {1'b0, base};
        if (off >= (IW+1)'(NROT))
            off = off - (IW+1)'(NROT);
        if (idx < IW'(NSTAT))
            phys = idx;
        else
            phys = IW'(off + (IW+1)'(NSTAT));
    end
endmodule

// File: rtl/pred_rot_base.sv
// Module: pred_rot_base
// Holds the rotation base register.
// A load is accepted only when the offered value lies inside the rotating region.
// Assumes synchronous active-low reset.
module pred_rot_base #(
    parameter int NPRED = 64,
    parameter int NSTAT = 16,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [IW-1:0] ld_val,
    output logic [IW-1:0] q
);
    localparam int NROT = NPRED - NSTAT;

    // Purpose: reset to zero; load only legal base values.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (ld && (ld_val < IW'(NROT)))
            q <= ld_val;
    end

    assert_base_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q < IW'(NROT));
    assert_base_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/pred_store.sv
// Module: pred_store
// Physical predicate storage.
// Entry 0 is a constant one. Every other entry takes a single write, a whole-file write, or holds.
// The whole-file write wins when both hit the same entry.
// Mask bit NSTAT covers every rotating entry. Mask bit 0 is never consulted.
module pred_store #(
    parameter int NPRED = 64,
    parameter int NSTAT = 16,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_we,
    input  logic [IW-1:0]    s_phys,
    input  logic             s_bit,
    input  logic             b_we,
    input  logic [NPRED-1:0] b_val,
    input  logic [NSTAT:0]   b_mask,
    output logic [NPRED-1:0] q
);
    assign q[0] = 1'b1;

    for (genvar e = 1; e < NPRED; e++) begin : g_ent
        localparam int MB = (e < NSTAT) ? e : NSTAT;
        logic b_hit;
        logic s_hit;
        assign b_hit = b_we && b_mask[MB];
        assign s_hit = s_we && (s_phys == IW'(e));

        // Purpose: next value of one predicate entry with whole-file priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[e] <= 1'b0;
            else if (b_hit)
                q[e] <= b_val[e];
            else if (s_hit)
                q[e] <= s_bit;
        end

        assert_bulk_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (b_we && b_mask[MB]) |=> q[e] == $past(b_val[e]));
    end

    assert_rot_group_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && !b_mask[NSTAT] && !s_we) |=> q[NPRED-1:NSTAT] == $past(q[NPRED-1:NSTAT]));
endmodule

// File: rtl/pred_xfer_top.sv
// Module: pred_xfer_top
// Predicate file with renamed single access and unrenamed whole-file transfer.
// Reads are combinational. Writes and base loads land at the next rising edge.
// Assumes synchronous active-low reset.
module pred_xfer_top #(
    parameter int NPRED = pred_pkg::PRED_N,
    parameter int NSTAT = pred_pkg::STATIC_N,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    output logic             rd_bit,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_bit,
    input  logic             bulk_we,
    input  logic [NPRED-1:0] bulk_val,
    input  logic [NSTAT:0]   bulk_mask,
    input  logic             base_we,
    input  logic [IW-1:0]    base_val,
    output logic [IW-1:0]    base_q,
    output logic [NPRED-1:0] bulk_out
);
    logic [IW-1:0]    rd_phys;
    logic [IW-1:0]    wr_phys;
    logic [NPRED-1:0] st_q;

    pred_rot_base #(.NPRED(NPRED), .NSTAT(NSTAT)) u_base (
        .clk(clk), .rst_n(rst_n), .ld(base_we), .ld_val(base_val), .q(base_q));

    pred_rot_map #(.NPRED(NPRED), .NSTAT(NSTAT)) u_rmap (
        .idx(rd_idx), .base(base_q), .phys(rd_phys));

    pred_rot_map #(.NPRED(NPRED), .NSTAT(NSTAT)) u_wmap (
        .idx(wr_idx), .base(base_q), .phys(wr_phys));

    pred_store #(.NPRED(NPRED), .NSTAT(NSTAT)) u_store (
        .clk(clk), .rst_n(rst_n),
        .s_we(wr_en), .s_phys(wr_phys), .s_bit(wr_bit),
        .b_we(bulk_we), .b_val(bulk_val), .b_mask(bulk_mask),
        .q(st_q));

    // Purpose: drive both read views from the physical store.
    always_comb begin
        bulk_out = st_q;
        rd_bit   = st_q[rd_phys];
    end

    assert_rename_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx >= IW'(NSTAT)) |-> (wr_phys >= IW'(NSTAT)));
    assert_single_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bulk_we && wr_phys != '0) |=> bulk_out[$past(wr_phys)] == $past(wr_bit));
    assert_p0_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> bulk_out[0]);
endmodule

// File: tb/pred_xfer_top_test.sv
module pred_xfer_top_test;
    localparam int NP = 64;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    rd_idx = '0;
    logic          rd_bit;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_idx = '0;
    logic          wr_bit = 1'b0;
    logic          bulk_we = 1'b0;
    logic [NP-1:0] bulk_val = '0;
    logic [NS:0]   bulk_mask = '0;
    logic          base_we = 1'b0;
    logic [5:0]    base_val = '0;
    logic [5:0]    base_q;
    logic [NP-1:0] bulk_out;

    always #2.5 clk = ~clk;

    pred_xfer_top uut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_bit(rd_bit),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(wr_bit),
        .bulk_we(bulk_we), .bulk_val(bulk_val), .bulk_mask(bulk_mask),
        .base_we(base_we), .base_val(base_val), .base_q(base_q), .bulk_out(bulk_out));

    typedef struct {
        logic [NP-1:0] f;
        logic          r;
        logic [5:0]    b;
        string         tag;
    } exp_t;

    exp_t     sbq[$];
    int       checks = 0;
    int       fails = 0;
    logic     m[NP];
    int       mb = 0;
    bit       done = 0;

    function automatic int phys(int i, int b);
        if (i < NS) return i;
        return NS + ((i - NS + b) % (NP - NS));
    endfunction

    function automatic logic [NP-1:0] mvec();
        logic [NP-1:0] v;
        for (int k = 0; k < NP; k++) v[k] = m[k];
        return v;
    endfunction

    // one stimulus cycle, model update, expected pushed to scoreboard
    task automatic step(input bit we, input int wi, input bit wb,
                        input bit bwe, input logic [NP-1:0] bv, input logic [NS:0] bm,
                        input bit lwe, input int lv, input int ri, input string tag);
        int oldb;
        exp_t x;
        @(posedge clk); #1;
        wr_en = we; wr_idx = 6'(wi); wr_bit = wb;
        bulk_we = bwe; bulk_val = bv; bulk_mask = bm;
        base_we = lwe; base_val = 6'(lv); rd_idx = 6'(ri);
        @(posedge clk); #1;
        wr_en = 0; bulk_we = 0; base_we = 0;
        oldb = mb;
        if (we && phys(wi, oldb) != 0) m[phys(wi, oldb)] = wb;
        if (bwe)
            for (int k = 1; k < NP; k++)
                if (bm[(k < NS) ? k : NS]) m[k] = bv[k];
        if (lwe && lv < NP - NS) mb = lv;
        x.f = mvec(); x.r = m[phys(ri, mb)]; x.b = 6'(mb); x.tag = tag;
        sbq.push_back(x);
    endtask

    // monitor: compare on the falling edge after each push
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t x;
                x = sbq.pop_front();
                checks += 3;
                if (bulk_out !== x.f) begin
                    fails++;
                    $display("FAIL %s bulk_out act=%h exp=%h", x.tag, bulk_out, x.f);
                end
                if (rd_bit !== x.r) begin
                    fails++;
                    $display("FAIL %s rd_bit act=%b exp=%b", x.tag, rd_bit, x.r);
                end
                if (base_q !== x.b) begin
                    fails++;
                    $display("FAIL %s base_q act=%0d exp=%0d", x.tag, base_q, x.b);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] pat;
        for (int k = 0; k < NP; k++) m[k] = 1'b0;
        m[0] = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (bulk_out !== 64'h1 || base_q !== 6'd0) begin
            fails++;
            $display("FAIL R1 reset act=%h/%0d exp=%h/0", bulk_out, base_q, 64'h1);
        end
        step(1, 3, 1, 0, '0, '0, 0, 0, 3, "R3 static single write");
        step(1, 0, 0, 0, '0, '0, 0, 0, 0, "R2 write to p0");
        step(0, 0, 0, 1, '0, 17'h1ffff, 0, 0, 0, "R2 bulk zero p0");
        step(0, 0, 0, 0, '0, '0, 1, 5, 16, "R5 base load 5");
        step(1, 16, 1, 0, '0, '0, 0, 0, 16, "R4 idx16 base5");
        step(1, 60, 1, 0, '0, '0, 0, 0, 60, "R4 wrap idx60");
        step(0, 0, 0, 0, '0, '0, 1, 50, 60, "R5 base 50 ignored");
        step(0, 0, 0, 0, '0, '0, 1, 47, 63, "R5 base load 47");
        step(1, 63, 1, 0, '0, '0, 0, 0, 63, "R4 idx63 base47");
        step(0, 0, 0, 1, '1, 17'h08004, 0, 0, 2, "R7 static mask bits");
        step(0, 0, 0, 1, '0, 17'h00001, 0, 0, 15, "R8 mask bit0 ignored");
        pat = 64'hA5C3_0F96_1E2D_7B48;
        step(0, 0, 0, 1, pat, 17'h10000, 0, 0, 20, "R8 rotating group");
        step(0, 0, 0, 1, ~pat, 17'h10000, 1, 7, 33, "R9 bulk with base load");
        step(0, 0, 0, 0, '0, '0, 0, 0, 33, "R6 whole read");
        step(1, 5, 1, 1, '0, 17'h00020, 0, 0, 5, "R10 static collision");
        step(1, 40, 1, 1, '0, 17'h10000, 0, 0, 40, "R10 rotating collision");
        step(1, 9, 1, 1, '0, 17'h10000, 0, 0, 9, "R10 no overlap");
        for (int k = 0; k < 6; k++)
            step(1, 16 + k * 8, k % 2, 0, '0, '0, 1, k * 9, 16 + k * 8, "R4 sweep");
        repeat (3) @(posedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule